// File: doc/BRIEF.md
# Atomic Read-Modify-Write Memory Unit

This block owns a small single-ported word memory and performs indivisible read-modify-write operations on it. A requester presents an opcode, a word address and up to two 64-bit operands with a valid/ready handshake. The unit reads the addressed word, decides whether and what to write back, and returns the word it found together with a status bit. Four primitives share this one datapath: exchange, test-and-set, fetch-and-add and compare-and-swap. Each primitive touches memory once, so a lock attempt that fails costs one access, not a load followed by a separate exchange.

The controller is a four-state machine. In `ST_IDLE` it accepts a request and latches it (transition IDLE→READ). In `ST_READ` the memory returns the addressed word into its output register (READ→MODIFY). In `ST_MODIFY` the update logic decides the write-back and commits it at the clock edge while the old word and status are captured (MODIFY→REPLY). In `ST_REPLY` the response is presented for one cycle (REPLY→IDLE). `req_ready` is high only in `ST_IDLE`, so no other request can reach memory between the read and the write of an operation.

Top module: `atomic_rmw_unit`

## Requirements
- R1: After reset `req_ready` is 1, `rsp_valid` is 0 and every memory word reads as zero.
- R2: A request is taken on a rising edge where `req_valid` and `req_ready` are both 1. `req_ready` is then 0 for the next three cycles. `rsp_valid` is 0 in the first two of those cycles and 1 in the third. In the following cycle `rsp_valid` is 0 and `req_ready` is 1.
- R3: A request presented while `req_ready` is 0 is neither executed nor queued. It has no effect on memory.
- R4: Opcode 0 (exchange) writes `req_opa` into the word, returns the old word, and sets `rsp_ok` to 1.
- R5: Opcode 1 (test-and-set) returns the old word. It writes 1 into the word only when the old word was 0, and then sets `rsp_ok` to 1. Otherwise it leaves the word unchanged and sets `rsp_ok` to 0. The operands are ignored.
- R6: Opcode 2 (fetch-and-add) returns the old word and writes back old + `req_opa` modulo 2^64. It has no overflow indication, and `rsp_ok` is 1.
- R7: Opcode 3 (compare-and-swap) compares `req_opb` (expected) with the word. When they are equal, it writes `req_opa` and sets `rsp_ok` to 1. In both cases it returns the old word.
- R8: A compare-and-swap whose expected value differs from the word sets `rsp_ok` to 0 and leaves the word unchanged.
- R9: Every address in the range 0 to DEPTH-1, including the highest one, selects its own independent word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset; also clears the memory |
| req_valid | input | 1 | A request is presented |
| req_ready | output | 1 | Unit is idle and will take a request at this edge |
| req_op | input | 2 | 0 exchange, 1 test-and-set, 2 fetch-and-add, 3 compare-and-swap |
| req_addr | input | AW (4) | Word address |
| req_opa | input | DW (64) | Exchange value, addend, or compare-and-swap new value |
| req_opb | input | DW (64) | Compare-and-swap expected value |
| rsp_valid | output | 1 | One-cycle pulse carrying the result |
| rsp_old | output | DW (64) | Word contents before the operation |
| rsp_ok | output | 1 | Success status as defined per opcode |

## Verification
A corrupted controller state appears at the handshake pins first. A stuck or skipped state moves the `rsp_valid` pulse away from the third cycle after acceptance, or raises `req_ready` early. This is visible within four cycles of the faulty request. A wrong write-back decision stays hidden until the same address is accessed again. For this reason the stimulus re-reads every modified word with a later exchange, so a bad update shows up in `rsp_old` of the next operation on that word. Failed compare-and-swap and test-and-set attempts are each followed by an access that exposes any stray write.

// File: rtl/atomic_rmw_pkg.sv
package atomic_rmw_pkg;

    typedef enum logic [1:0] {
        OP_SWAP = 2'd0,
        OP_TAS  = 2'd1,
        OP_FADD = 2'd2,
        OP_CAS  = 2'd3
    } amo_op_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_READ   = 2'd1,
        ST_MODIFY = 2'd2,
        ST_REPLY  = 2'd3
    } amo_state_e;

endpackage

// File: rtl/atomic_word_mem.sv
module atomic_word_mem #(
    parameter int DW    = 64,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          we,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] words [DEPTH];

    // single port: registered read, write on the same edge returns the old word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                words[i] <= '0;
            end
            rdata <= '0;
        end else begin
            rdata <= words[addr];
            if (we) begin
                words[addr] <= wdata;
            end
        end
    end

endmodule

// File: rtl/atomic_op_alu.sv
module atomic_op_alu
    import atomic_rmw_pkg::*;
#(
    parameter int DW = 64
) (
    input  amo_op_e       op,
    input  logic [DW-1:0] old_word,
    input  logic [DW-1:0] opa,
    input  logic [DW-1:0] opb,
    output logic [DW-1:0] new_word,
    output logic          do_write,
    output logic          ok
);

    localparam logic [DW-1:0] ONE = DW'(1);

    logic old_is_zero;
    logic cmp_hit;

    assign old_is_zero = (old_word == '0);
    assign cmp_hit     = (old_word == opb);

    always_comb begin
        new_word = old_word;
        do_write = 1'b0;
        ok       = 1'b1;
        unique case (op)
            OP_SWAP: begin
                new_word = opa;
                do_write = 1'b1;
            end
            OP_TAS: begin
                new_word = ONE;
                do_write = old_is_zero;
                ok       = old_is_zero;
            end
            OP_FADD: begin
                new_word = old_word + opa;
                do_write = 1'b1;
            end
            OP_CAS: begin
                new_word = opa;
                do_write = cmp_hit;
                ok       = cmp_hit;
            end
        endcase
    end

endmodule

// File: rtl/atomic_rmw_unit.sv
module atomic_rmw_unit
    import atomic_rmw_pkg::*;
#(
    parameter int DW    = 64,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [1:0]    req_op,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_opa,
    input  logic [DW-1:0] req_opb,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_old,
    output logic          rsp_ok
);

    amo_state_e    state, state_nx;
    amo_op_e       op_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] opa_q, opb_q;
    logic [DW-1:0] old_q;
    logic          ok_q;

    logic [DW-1:0] mem_rdata;
    logic [DW-1:0] mem_wdata;
    logic          mem_we;
    logic          alu_write;
    logic          alu_ok;
    logic          take;

    assign take = req_valid && req_ready;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // transitions: IDLE->READ on accept, then READ->MODIFY->REPLY->IDLE
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (take) state_nx = ST_READ;
            ST_READ:   state_nx = ST_MODIFY;
            ST_MODIFY: state_nx = ST_REPLY;
            ST_REPLY:  state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_ready = 1'b0;
        rsp_valid = 1'b0;
        mem_we    = 1'b0;
        unique case (state)
            ST_IDLE:   req_ready = 1'b1;
            ST_READ:   ;
            ST_MODIFY: mem_we = alu_write;
            ST_REPLY:  rsp_valid = 1'b1;
        endcase
    end

    assign rsp_old = old_q;
    assign rsp_ok  = ok_q;

    // request latch and result capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q   <= OP_SWAP;
            addr_q <= '0;
            opa_q  <= '0;
            opb_q  <= '0;
            old_q  <= '0;
            ok_q   <= 1'b0;
        end else begin
            if (take) begin
                op_q   <= amo_op_e'(req_op);
                addr_q <= req_addr;
                opa_q  <= req_opa;
                opb_q  <= req_opb;
            end
            if (state == ST_MODIFY) begin
                old_q <= mem_rdata;
                ok_q  <= alu_ok;
            end
        end
    end

    atomic_word_mem #(
        .DW    (DW),
        .DEPTH (DEPTH)
    ) i_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (addr_q),
        .we    (mem_we),
        .wdata (mem_wdata),
        .rdata (mem_rdata)
    );

    atomic_op_alu #(
        .DW (DW)
    ) i_alu (
        .op       (op_q),
        .old_word (mem_rdata),
        .opa      (opa_q),
        .opb      (opb_q),
        .new_word (mem_wdata),
        .do_write (alu_write),
        .ok       (alu_ok)
    );

endmodule

// File: rtl/atomic_rmw_checker.sv
module atomic_rmw_checker #(
    parameter int DW = 64,
    parameter int AW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_ready,
    input logic          rsp_valid,
    input logic [1:0]    state,
    input logic [1:0]    op_q,
    input logic          mem_we,
    input logic [DW-1:0] mem_wdata,
    input logic [DW-1:0] mem_rdata,
    input logic [DW-1:0] opb_q
);

    assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    assert_reply_third_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> ##1 (!rsp_valid && !req_ready) ##1 rsp_valid);

    assert_reply_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (!rsp_valid && req_ready));

    assert_no_accept_while_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);

    assert_write_only_in_modify_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (state == 2'd2));

    assert_tas_writes_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && op_q == 2'd1) |-> (mem_wdata == DW'(1)));

    assert_cas_miss_no_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 2'd2 && op_q == 2'd3 && mem_rdata != opb_q) |-> !mem_we);

endmodule

bind atomic_rmw_unit atomic_rmw_checker #(
    .DW (DW),
    .AW (AW)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .state     (state),
    .op_q      (op_q),
    .mem_we    (mem_we),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .opb_q     (opb_q)
);

// File: tb/test_atomic_rmw_unit.sv
`timescale 1ns/1ps
module test_atomic_rmw_unit;

    localparam int DW = 64;
    localparam int DEPTH = 16;
    localparam int AW = 4;
    localparam int NV = 18;
    localparam int VW = 2 + AW + 3*DW + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [1:0]    req_op = '0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_opa = '0;
    logic [DW-1:0] req_opb = '0;
    logic          rsp_valid;
    logic [DW-1:0] rsp_old;
    logic          rsp_ok;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    atomic_rmw_unit #(.DW(DW), .DEPTH(DEPTH)) i_atomic_rmw_unit (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr),
        .req_opa(req_opa), .req_opb(req_opb),
        .rsp_valid(rsp_valid), .rsp_old(rsp_old), .rsp_ok(rsp_ok)
    );

    // op, addr, opa, opb, expected old, expected ok
    localparam logic [VW-1:0] VEC [NV] = '{
        {2'd0, 4'd3,  64'h1111, 64'h0, 64'h0, 1'b1},
        {2'd0, 4'd3,  64'h2222, 64'h0, 64'h1111, 1'b1},
        {2'd1, 4'd5,  64'h0, 64'h0, 64'h0, 1'b1},
        {2'd1, 4'd5,  64'h0, 64'h0, 64'h1, 1'b0},
        {2'd2, 4'd7,  64'h5, 64'h0, 64'h0, 1'b1},
        {2'd2, 4'd7,  64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 64'h5, 1'b1},
        {2'd0, 4'd7,  64'h0, 64'h0, 64'h4, 1'b1},
        {2'd3, 4'd3,  64'hAAAA, 64'h9999, 64'h2222, 1'b0},
        {2'd3, 4'd3,  64'hAAAA, 64'h2222, 64'h2222, 1'b1},
        {2'd0, 4'd3,  64'h0, 64'h0, 64'hAAAA, 1'b1},
        {2'd0, 4'd5,  64'hDEAD, 64'h0, 64'h1, 1'b1},
        {2'd1, 4'd5,  64'h0, 64'h0, 64'hDEAD, 1'b0},
        {2'd0, 4'd5,  64'h0, 64'h0, 64'hDEAD, 1'b1},
        {2'd1, 4'd15, 64'h0, 64'h0, 64'h0, 1'b1},
        {2'd0, 4'd15, 64'h0, 64'h0, 64'h1, 1'b1},
        {2'd2, 4'd0,  64'h8000_0000_0000_0000, 64'h0, 64'h0, 1'b1},
        {2'd2, 4'd0,  64'h8000_0000_0000_0000, 64'h0, 64'h8000_0000_0000_0000, 1'b1},
        {2'd0, 4'd0,  64'h0, 64'h0, 64'h0, 1'b1}
    };

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one operation; optionally keeps a competing request on the pins while busy
    task automatic run_op(input logic [1:0] op, input logic [AW-1:0] addr,
                          input logic [DW-1:0] a, input logic [DW-1:0] b,
                          input bit noise, input string tag,
                          output logic [DW-1:0] old, output logic ok);
        @(negedge clk);
        check({tag, " R2 ready when idle"}, DW'(req_ready), DW'(1));
        req_valid = 1'b1; req_op = op; req_addr = addr; req_opa = a; req_opb = b;
        @(negedge clk);
        if (noise) begin
            req_op = 2'd0; req_addr = 4'd9; req_opa = 64'h77; req_opb = '0;
        end else begin
            req_valid = 1'b0;
        end
        check({tag, " R2 busy cycle1"}, DW'({req_ready, rsp_valid}), DW'(0));
        @(negedge clk);
        check({tag, " R2 busy cycle2"}, DW'({req_ready, rsp_valid}), DW'(0));
        @(negedge clk);
        check({tag, " R2 reply cycle3"}, DW'({req_ready, rsp_valid}), DW'(1));
        old = rsp_old;
        ok = rsp_ok;
        req_valid = 1'b0;
        @(negedge clk);
        check({tag, " R2 back to idle"}, DW'({req_ready, rsp_valid}), DW'(2));
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        logic [DW-1:0] old;
        logic ok;
        string tag;
        repeat (4) @(negedge clk);
        check("R1 ready after reset", DW'(req_ready), DW'(1));
        check("R1 no reply after reset", DW'(rsp_valid), DW'(0));
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 ready after release", DW'(req_ready), DW'(1));
        check("R1 idle reply low", DW'(rsp_valid), DW'(0));

        for (int i = 0; i < NV; i++) begin
            logic [1:0]    v_op;
            logic [AW-1:0] v_addr;
            logic [DW-1:0] v_a, v_b, v_old;
            logic          v_ok;
            {v_op, v_addr, v_a, v_b, v_old, v_ok} = VEC[i];
            case (v_op)
                2'd0: tag = "R4";
                2'd1: tag = "R5";
                2'd2: tag = "R6";
                default: tag = "R7";
            endcase
            if (i == 7) tag = "R8";
            if (i == 14 || i == 17) tag = "R9";
            tag = $sformatf("%s vec%0d", tag, i);
            run_op(v_op, v_addr, v_a, v_b, 1'b0, tag, old, ok);
            check({tag, " old"}, old, v_old);
            check({tag, " ok"}, DW'(ok), DW'(v_ok));
        end

        // R8: failed compare leaves word intact; verify with a read-back
        run_op(2'd0, 4'd11, 64'h55, 64'h0, 1'b0, "R8 setup", old, ok);
        run_op(2'd3, 4'd11, 64'h99, 64'h54, 1'b0, "R8 miss", old, ok);
        check("R8 miss status", DW'(ok), DW'(0));
        run_op(2'd0, 4'd11, 64'h0, 64'h0, 1'b0, "R8 readback", old, ok);
        check("R8 word unchanged", old, 64'h55);

        // R3: competing request held while busy must not execute
        run_op(2'd0, 4'd2, 64'hBEEF, 64'h0, 1'b1, "R3 busy", old, ok);
        check("R3 primary old", old, 64'h0);
        run_op(2'd0, 4'd9, 64'h0, 64'h0, 1'b0, "R3 readback", old, ok);
        check("R3 ignored request left word", old, 64'h0);

        // R1: untouched word still zero after earlier traffic
        run_op(2'd1, 4'd12, 64'h0, 64'h0, 1'b0, "R1 zero word", old, ok);
        check("R1 untouched word zero", old, 64'h0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule